// File: doc/BRIEF.md
# First-Come Clock and Reset Strobe Qualifier

This block sits in front of a small serial one-time-programmable memory. It watches two active-low pulse pins. The advance pin steps the memory's address counter and the restart pin returns it to the first address. A third pin, the hold select, freezes the counter. The block turns the pin activity into clean single-cycle strobes in the system clock domain. For each pulse it accepts, it emits a fall strobe when the pulse begins. It emits a rise strobe when the pulse ends, and the memory uses that rise to latch its output data.

The two pulse pins are arbitrated first-come. The pin that falls first owns the cycle until it rises again, and any pulse on the other pin during that time is thrown away. The qualifier accepts no new pulse until it has seen both pins high together. The hold select only takes effect in a cycle where both pins are high, so a change of mode never cuts a pulse in half. While hold is selected or in effect, pulses produce no strobes at all. A pulse that started during hold also produces no strobes if it is still low when hold is released. All three pins pass through two-flop synchronisers before any edge detection.

Top module: `pulse_strobe_qualifier`

## Requirements
- R1: Each pin passes through a two-flop synchroniser, so an accepted fall on a pin gives its fall strobe for one cycle, seen after the third rising clock edge after the pin changes.
- R2: No more than one of the four strobes (advance fall, advance rise, restart fall, restart rise) is high in any cycle, and each strobe lasts one cycle.
- R3: When one pin falls while the block is armed and the mode is read (hold_mode low, hold_sel low), that pin's fall strobe fires. Its rise strobe fires when the same pin returns high.
- R4: When both pins fall in the same sampled cycle, the restart pin wins. Only restart strobes are produced, and the advance pulse is ignored.
- R5: While one pin owns the cycle, pulses on the other pin produce no strobes. After the owner rises, no pulse is accepted until both pins have been high together.
- R6: A pulse that falls while hold_mode or hold_sel is high produces neither a fall nor a rise strobe.
- R7: hold_mode follows hold_sel (1 = hold) only in a cycle where both synchronised pins are high. mode_ack pulses for one cycle exactly when hold_mode changes.
- R8: A pulse that began during hold and is still low when hold_sel returns low produces no strobes. hold_mode drops only once that pulse has ended.
- R9: During and right after reset all strobes and mode_ack are low and hold_mode is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adv_pin_n | input | 1 | Raw advance pulse pin, active low |
| restart_pin_n | input | 1 | Raw restart pulse pin, active low |
| hold_sel | input | 1 | Raw mode select, 1 = counter hold |
| adv_fall | output | 1 | Accepted advance pulse began |
| adv_rise | output | 1 | Accepted advance pulse ended (latch point) |
| restart_fall | output | 1 | Accepted restart pulse began |
| restart_rise | output | 1 | Accepted restart pulse ended (latch point) |
| mode_ack | output | 1 | One-cycle pulse when hold_mode changes |
| hold_mode | output | 1 | Mode in effect, 1 = hold |

## Verification
The arbitration is driven with isolated pulses on each pin and with overlapping pulses in both orders. This separates a correct first-come owner from a design that favours one pin or reacts to both. Falls in the same cycle show that restart wins the tie. A second fall on the loser's pin before both pins return high shows whether re-arming really waits for both. Mode changes are requested while a pulse is low, in both directions, to tell deferred switching from immediate switching. A fixed latency test pins down the synchroniser depth.

// File: rtl/sqz_pkg.sv
package sqz_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_ADV  = 2'd1,
        ARB_RST  = 2'd2,
        ARB_WAIT = 2'd3
    } arb_state_e;

    typedef struct packed {
        arb_state_e st;
        logic       adv_prev;
        logic       rst_prev;
        logic       hold;
        logic       adv_fall;
        logic       adv_rise;
        logic       rst_fall;
        logic       rst_rise;
        logic       ack;
    } arb_regs_t;

endpackage

// File: rtl/sqz_sync.sv
module sqz_sync #(
    parameter int                 WIDTH   = 1,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [WIDTH-1:0] stage_d;
        if (g == 0) begin : g_first
            assign stage_d = d;
        end else begin : g_next
            assign stage_d = stage_q[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= RST_VAL;
            else        stage_q[g] <= stage_d;
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sqz_arbiter.sv
module sqz_arbiter
    import sqz_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic adv_s,
    input  logic rst_s,
    input  logic sel_s,
    output logic adv_fall,
    output logic adv_rise,
    output logic rst_fall,
    output logic rst_rise,
    output logic mode_ack,
    output logic hold_mode
);
    localparam arb_regs_t RESET_REGS = '{
        st: ARB_IDLE, adv_prev: 1'b1, rst_prev: 1'b1, hold: 1'b0,
        adv_fall: 1'b0, adv_rise: 1'b0, rst_fall: 1'b0, rst_rise: 1'b0,
        ack: 1'b0
    };

    arb_regs_t r_d, r_q;

    logic adv_dn, adv_up, rst_dn, rst_up, both_hi, blocked;

    always_comb begin
        adv_dn  = r_q.adv_prev & ~adv_s;
        adv_up  = ~r_q.adv_prev & adv_s;
        rst_dn  = r_q.rst_prev & ~rst_s;
        rst_up  = ~r_q.rst_prev & rst_s;
        both_hi = adv_s & rst_s;
        blocked = r_q.hold | sel_s;

        r_d          = r_q;
        r_d.adv_prev = adv_s;
        r_d.rst_prev = rst_s;
        r_d.adv_fall = 1'b0;
        r_d.adv_rise = 1'b0;
        r_d.rst_fall = 1'b0;
        r_d.rst_rise = 1'b0;
        r_d.ack      = 1'b0;

        unique case (r_q.st)
            ARB_IDLE: begin
                if (!blocked && rst_dn) begin
                    r_d.st       = ARB_RST;
                    r_d.rst_fall = 1'b1;
                end else if (!blocked && adv_dn) begin
                    r_d.st       = ARB_ADV;
                    r_d.adv_fall = 1'b1;
                end else if (adv_dn || rst_dn) begin
                    r_d.st = ARB_WAIT;
                end
            end
            ARB_ADV: begin
                if (adv_up) begin
                    r_d.adv_rise = 1'b1;
                    r_d.st       = rst_s ? ARB_IDLE : ARB_WAIT;
                end
            end
            ARB_RST: begin
                if (rst_up) begin
                    r_d.rst_rise = 1'b1;
                    r_d.st       = adv_s ? ARB_IDLE : ARB_WAIT;
                end
            end
            ARB_WAIT: begin
                if (both_hi) r_d.st = ARB_IDLE;
            end
            default: r_d.st = ARB_WAIT;
        endcase

        if (both_hi && (sel_s != r_q.hold)) begin
            r_d.hold = sel_s;
            r_d.ack  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_REGS;
        else        r_q <= r_d;
    end

    assign adv_fall  = r_q.adv_fall;
    assign adv_rise  = r_q.adv_rise;
    assign rst_fall  = r_q.rst_fall;
    assign rst_rise  = r_q.rst_rise;
    assign mode_ack  = r_q.ack;
    assign hold_mode = r_q.hold;
endmodule

// File: rtl/pulse_strobe_qualifier.sv
module pulse_strobe_qualifier #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_pin_n,
    input  logic restart_pin_n,
    input  logic hold_sel,
    output logic adv_fall,
    output logic adv_rise,
    output logic restart_fall,
    output logic restart_rise,
    output logic mode_ack,
    output logic hold_mode
);
    localparam int         NPINS    = 3;
    localparam logic [2:0] PIN_IDLE = 3'b110;

    logic [NPINS-1:0] pins_raw, pins_s;

    assign pins_raw = {adv_pin_n, restart_pin_n, hold_sel};

    sqz_sync #(
        .WIDTH  (NPINS),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_IDLE)
    ) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pins_raw),
        .q    (pins_s)
    );

    sqz_arbiter arb_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv_s    (pins_s[2]),
        .rst_s    (pins_s[1]),
        .sel_s    (pins_s[0]),
        .adv_fall (adv_fall),
        .adv_rise (adv_rise),
        .rst_fall (restart_fall),
        .rst_rise (restart_rise),
        .mode_ack (mode_ack),
        .hold_mode(hold_mode)
    );
endmodule

// File: rtl/pulse_strobe_qualifier_chk.sv
module pulse_strobe_qualifier_chk (
    input logic clk,
    input logic rst_n,
    input logic adv_fall,
    input logic adv_rise,
    input logic restart_fall,
    input logic restart_rise,
    input logic mode_ack,
    input logic hold_mode
);
    logic pend_adv_q, pend_rst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_adv_q <= 1'b0;
            pend_rst_q <= 1'b0;
        end else begin
            if (adv_fall)          pend_adv_q <= 1'b1;
            else if (adv_rise)     pend_adv_q <= 1'b0;
            if (restart_fall)      pend_rst_q <= 1'b1;
            else if (restart_rise) pend_rst_q <= 1'b0;
        end
    end

    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({adv_fall, adv_rise, restart_fall, restart_rise}));

    a_r3_adv_rise_owned: assert property (@(posedge clk) disable iff (!rst_n)
        adv_rise |-> pend_adv_q);

    a_r3_rst_rise_owned: assert property (@(posedge clk) disable iff (!rst_n)
        restart_rise |-> pend_rst_q);

    a_r5_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_fall || restart_fall) |-> !(pend_adv_q || pend_rst_q));

    a_r6_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        hold_mode |-> !(adv_fall || restart_fall));

    a_r7_ack_marks_change: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ack |-> (hold_mode != $past(hold_mode)));

    a_r7_change_has_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_mode != $past(hold_mode)) |-> mode_ack);
endmodule

bind pulse_strobe_qualifier pulse_strobe_qualifier_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .adv_fall    (adv_fall),
    .adv_rise    (adv_rise),
    .restart_fall(restart_fall),
    .restart_rise(restart_rise),
    .mode_ack    (mode_ack),
    .hold_mode   (hold_mode)
);

// File: tb/pulse_strobe_qualifier_tb_top.sv
module pulse_strobe_qualifier_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic adv_pin_n = 1'b1;
    logic restart_pin_n = 1'b1;
    logic hold_sel = 1'b0;
    logic adv_fall, adv_rise, restart_fall, restart_rise, mode_ack, hold_mode;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pulse_strobe_qualifier dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .adv_pin_n    (adv_pin_n),
        .restart_pin_n(restart_pin_n),
        .hold_sel     (hold_sel),
        .adv_fall     (adv_fall),
        .adv_rise     (adv_rise),
        .restart_fall (restart_fall),
        .restart_rise (restart_rise),
        .mode_ack     (mode_ack),
        .hold_mode    (hold_mode)
    );

    // {req[3:0], adv, rst, sel, #adv_fall, #adv_rise, #rst_fall, #rst_rise, #ack, hold}
    localparam int NV = 29;
    localparam logic [12:0] VEC [NV] = '{
        {4'd9, 3'b110, 6'b000000},  // R9 idle
        {4'd3, 3'b010, 6'b100000},  // R3 advance falls
        {4'd3, 3'b110, 6'b010000},  // R3 advance rises
        {4'd3, 3'b100, 6'b001000},  // R3 restart falls
        {4'd3, 3'b110, 6'b000100},  // R3 restart rises
        {4'd5, 3'b010, 6'b100000},  // R5 advance owns
        {4'd5, 3'b000, 6'b000000},  // R5 restart ignored
        {4'd5, 3'b100, 6'b010000},  // R5 owner rises
        {4'd5, 3'b000, 6'b000000},  // R5 not re-armed
        {4'd5, 3'b100, 6'b000000},  // R5
        {4'd5, 3'b110, 6'b000000},  // R5 both high, re-armed
        {4'd3, 3'b100, 6'b001000},  // R3 restart first
        {4'd5, 3'b000, 6'b000000},  // R5 advance ignored
        {4'd3, 3'b010, 6'b000100},  // R3 restart ends
        {4'd5, 3'b110, 6'b000000},  // R5
        {4'd4, 3'b000, 6'b001000},  // R4 tie, restart wins
        {4'd4, 3'b110, 6'b000100},  // R4
        {4'd7, 3'b111, 6'b000011},  // R7 enter hold
        {4'd6, 3'b011, 6'b000001},  // R6 blocked
        {4'd6, 3'b111, 6'b000001},  // R6
        {4'd6, 3'b101, 6'b000001},  // R6
        {4'd6, 3'b111, 6'b000001},  // R6
        {4'd8, 3'b011, 6'b000001},  // R8 pulse in hold
        {4'd7, 3'b010, 6'b000001},  // R7 exit deferred
        {4'd8, 3'b110, 6'b000010},  // R8 exits, no rise
        {4'd3, 3'b010, 6'b100000},  // R3
        {4'd7, 3'b011, 6'b000000},  // R7 entry deferred
        {4'd7, 3'b111, 6'b010011},  // R7 rise then hold
        {4'd7, 3'b110, 6'b000010}   // R7 leave hold
    };

    task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int lat;
        int width;
        repeat (3) @(negedge clk);
        // R9 outputs quiet while in reset
        check("R9", {adv_fall, adv_rise, restart_fall, restart_rise, mode_ack, hold_mode}, 6'b0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R9", {adv_fall, adv_rise, restart_fall, restart_rise, mode_ack, hold_mode}, 6'b0);

        for (int v = 0; v < NV; v++) begin
            logic [2:0] cnt [6];
            logic [5:0] got, exp;
            adv_pin_n     = VEC[v][8];
            restart_pin_n = VEC[v][7];
            hold_sel      = VEC[v][6];
            for (int k = 0; k < 6; k++) cnt[k] = '0;
            for (int c = 0; c < 8; c++) begin
                @(negedge clk);
                cnt[0] += 3'(adv_fall);
                cnt[1] += 3'(adv_rise);
                cnt[2] += 3'(restart_fall);
                cnt[3] += 3'(restart_rise);
                cnt[4] += 3'(mode_ack);
            end
            got = {cnt[0][0] | (cnt[0] > 1 ? 1'bx : 1'b0),
                   cnt[1][0] | (cnt[1] > 1 ? 1'bx : 1'b0),
                   cnt[2][0] | (cnt[2] > 1 ? 1'bx : 1'b0),
                   cnt[3][0] | (cnt[3] > 1 ? 1'bx : 1'b0),
                   cnt[4][0] | (cnt[4] > 1 ? 1'bx : 1'b0),
                   hold_mode};
            exp = VEC[v][5:0];
            check($sformatf("R%0d step %0d", VEC[v][12:9], v), got, exp);
        end

        // R1 latency: fall strobe after third rising edge, one cycle wide (R2)
        adv_pin_n = 1'b0;
        lat = 0;
        width = 0;
        for (int c = 1; c <= 8; c++) begin
            @(negedge clk);
            if (adv_fall) begin
                if (lat == 0) lat = c;
                width++;
            end
        end
        tests++;
        if (lat != 3) begin
            fails++;
            $display("FAIL R1 latency actual=%0d expected=3", lat);
        end
        tests++;
        if (width != 1) begin
            fails++;
            $display("FAIL R2 width actual=%0d expected=1", width);
        end
        adv_pin_n = 1'b1;
        repeat (6) @(negedge clk);

        // R9 reset in hold clears mode
        hold_sel = 1'b1;
        repeat (6) @(negedge clk);
        check("R7 hold set", {5'b0, hold_mode}, 6'b000001);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset in hold", {adv_fall, adv_rise, restart_fall, restart_rise, mode_ack, hold_mode}, 6'b0);
        hold_sel = 1'b0;
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R9 after reset", {adv_fall, adv_rise, restart_fall, restart_rise, mode_ack, hold_mode}, 6'b0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule